// File: doc/BRIEF.md
# SPI-Controlled 16-Pin I/O Expander

This block gives a host 16 general-purpose pins through a four-wire serial slave port. The pins form two 8-bit halves: half A is pins 7..0 and half B is pins 15..8. Each pin has a direction bit, an input-inversion bit, a pull-up enable bit and an output latch bit. The block drives a per-pin output enable, a per-pin output value and a per-pin pull-up request. Pin inputs pass through a synchronizer before they are read.

Every transaction starts with an opcode byte, then a register address byte, then any number of data bytes. Data bytes go to the addressed register and then to the registers that follow it. In the register map the A and B bytes of each function sit at adjacent addresses, so one burst covers a 16-bit function with the A byte first. Five interrupt-related registers are kept as plain read/write storage only; nothing in the block acts on them.

The serial lines are oversampled in the system clock domain. The serial clock must therefore run at no more than about one eighth of the system clock.

Top module: `spi_gpio_expander`

## Requirements
- R1: Serial framing is mode 3. Data enters most significant bit first on the rising serial-clock edge and leaves on the falling edge, with chip select active low. A byte that is not complete when chip select rises is discarded.
- R2: The first byte must have bits 7..1 equal to 0100000. Bit 0 selects read when 1 and write when 0. Any other first byte makes the rest of the transaction write nothing and keeps miso_oe_o low.
- R3: The second byte is the register address. Each following data byte accesses the current address, then the address advances by one, so a two-byte burst covers the A byte (even address) and then the B byte.
- R4: After address 0x15 the address wraps to 0x00 within a burst.
- R5: After reset the direction register (0x00/0x01) holds 0xFFFF, so pin_oe_o is 0. Every other register is zero, so pin_o and pullup_en_o are 0.
- R6: A direction bit of 0 sets the matching pin_oe_o bit and drives the pin from the output latch. A direction bit of 1 makes the pin an input.
- R7: A bit set in the pull-up register (0x0C/0x0D) sets the matching pullup_en_o bit.
- R8: A read of 0x12/0x13 returns the synchronized pin_i levels XOR the inversion register (0x02/0x03). A write to 0x12/0x13 updates the output latch.
- R9: A read of 0x14/0x15 returns the output latch contents, and a write there updates the latch. pin_o always shows the latch.
- R10: Addresses 0x04-0x09 and 0x0E-0x11 read back the last value written to them.
- R11: Addresses 0x0A, 0x0B and any address above 0x15 read as zero and ignore writes.
- R12: In a read, the first data bit appears on the falling edge right after the address byte. miso_oe_o is high only while chip select is low in a read data phase, and it drops at once when chip select goes high.
- R13: A data byte whose last rising clock edge comes only one system cycle before chip select rises is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out, valid when miso_oe_o is high |
| miso_oe_o | output | 1 | Output enable for serial data out; low means released |
| pin_i | input | 16 | Pin input levels |
| pin_o | output | 16 | Pin output values (output latch) |
| pin_oe_o | output | 16 | Pin output enables, 1 = driven |
| pullup_en_o | output | 16 | Weak pull-up requests |

## Verification
The completion of a final data byte and the release of chip select can land in the same system cycle. In that cycle the controller sees a valid byte while it is already being returned to the opcode phase. The bench provokes this by raising chip select one system cycle after the last rising serial-clock edge of a pull-up write. It then judges the outcome at the pull-up outputs: the byte must land and the neighbouring byte must stay unchanged. The companion case, releasing chip select after four bits of a byte, must leave the same outputs untouched.

// File: rtl/spi_gpio_pkg.sv
package spi_gpio_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned NUM_REGS = 22;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned PINS     = 2 * BYTE_W;

  localparam logic [ADDR_W-1:0] ADDR_GPIO_A = 8'h12;
  localparam logic [ADDR_W-1:0] ADDR_GPIO_B = 8'h13;
  localparam logic [ADDR_W-1:0] ADDR_HOLE_A = 8'h0A;
  localparam logic [ADDR_W-1:0] ADDR_HOLE_B = 8'h0B;
  localparam logic [ADDR_W-1:0] ADDR_LAST   = 8'h15;
  localparam logic [ADDR_W-1:0] ADDR_END    = 8'h16;

  localparam int IX_IODIR = 0;
  localparam int IX_IPOL  = 2;
  localparam int IX_GPPU  = 12;
  localparam int IX_OLAT  = 20;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_SKIP} phase_e;
endpackage

// File: rtl/spi_gpio_sync.sv
module spi_gpio_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {STAGES{RST_VAL}};
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_gpio_frontend.sv
module spi_gpio_frontend
  import spi_gpio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_load_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              sel_o,
  output logic              miso_bit_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic s_sclk, s_cs_n, s_mosi;
  logic sclk_d, rise, fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] tx_buf;

  spi_gpio_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   ({s_sclk, s_cs_n, s_mosi})
  );

  assign rise  = s_sclk & ~sclk_d;
  assign fall  = ~s_sclk & sclk_d;
  assign sel_o = ~s_cs_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d     <= 1'b1;
      bit_cnt    <= '0;
      shreg      <= '0;
      tx_buf     <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      miso_bit_o <= 1'b0;
    end else begin
      sclk_d     <= s_sclk;
      rx_valid_o <= 1'b0;
      if (tx_load_i) tx_buf <= tx_byte_i;
      if (s_cs_n) begin
        bit_cnt <= '0;  // partial byte dropped
      end else begin
        if (rise) begin
          shreg   <= {shreg[BYTE_W-3:0], s_mosi};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
            rx_valid_o <= 1'b1;
            rx_byte_o  <= {shreg, s_mosi};
          end
        end
        if (fall) miso_bit_o <= tx_buf[CNT_W'(BYTE_W - 1) - bit_cnt];
      end
    end
  end
endmodule

// File: rtl/spi_gpio_ctrl.sv
module spi_gpio_ctrl
  import spi_gpio_pkg::*;
#(
  parameter logic [6:0] DEV_OPCODE = 7'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_valid_i,
  input  logic              sel_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_load_o,
  output logic              rd_phase_o,
  output logic [ADDR_W-1:0] ptr_o,
  output phase_e            phase_o
);
  phase_e            phase_q;
  logic              rd_q;
  logic [ADDR_W-1:0] ptr_q, ptr_nxt;

  assign ptr_nxt   = (ptr_q == ADDR_LAST) ? '0 : ptr_q + 1'b1;
  // prefetch the byte that the next falling edge shifts out
  assign rd_addr_o = (phase_q == PH_ADDR) ? rx_byte_i : ptr_nxt;
  assign tx_byte_o = rd_data_i;
  assign tx_load_o = rx_valid_i && rd_q && (phase_q == PH_ADDR || phase_q == PH_DATA);
  assign wr_en_o   = rx_valid_i && !rd_q && (phase_q == PH_DATA);
  assign wr_addr_o = ptr_q;
  assign wr_data_o = rx_byte_i;
  assign ptr_o     = ptr_q;
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_CMD;
      rd_q       <= 1'b0;
      ptr_q      <= '0;
      rd_phase_o <= 1'b0;
    end else begin
      if (rx_valid_i) begin
        unique case (phase_q)
          PH_CMD: begin
            if (rx_byte_i[7:1] == DEV_OPCODE) begin
              phase_q <= PH_ADDR;
              rd_q    <= rx_byte_i[0];
            end else begin
              phase_q <= PH_SKIP;
            end
          end
          PH_ADDR: begin
            ptr_q      <= rx_byte_i;
            phase_q    <= PH_DATA;
            rd_phase_o <= rd_q;
          end
          PH_DATA: ptr_q <= ptr_nxt;
          PH_SKIP: ;
          default: ;
        endcase
      end
      // deselect wins over the state update, not over the write above
      if (!sel_i) begin
        phase_q    <= PH_CMD;
        rd_phase_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_gpio_regs.sv
module spi_gpio_regs
  import spi_gpio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PINS-1:0]   pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [PINS-1:0]   pin_o,
  output logic [PINS-1:0]   pin_oe_o,
  output logic [PINS-1:0]   pullup_en_o
);
  logic [NUM_REGS-1:0][BYTE_W-1:0] mem;
  logic [PINS-1:0]   pin_s;
  logic [ADDR_W-1:0] wr_tgt;
  logic              wr_ok;

  spi_gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  function automatic logic is_void(input logic [ADDR_W-1:0] a);
    return (a >= ADDR_END) || (a == ADDR_HOLE_A) || (a == ADDR_HOLE_B);
  endfunction

  // pin-level writes land in the output latch
  assign wr_tgt = (wr_addr_i == ADDR_GPIO_A || wr_addr_i == ADDR_GPIO_B)
                  ? wr_addr_i + ADDR_W'(2) : wr_addr_i;
  assign wr_ok  = wr_en_i && !is_void(wr_tgt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= (i < 2) ? '1 : '0;
    end else if (wr_ok) begin
      mem[wr_tgt[IDX_W-1:0]] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_GPIO_A)      rd_data_o = pin_s[BYTE_W-1:0] ^ mem[IX_IPOL];
    else if (rd_addr_i == ADDR_GPIO_B) rd_data_o = pin_s[PINS-1:BYTE_W] ^ mem[IX_IPOL+1];
    else if (!is_void(rd_addr_i))      rd_data_o = mem[rd_addr_i[IDX_W-1:0]];
  end

  assign pin_oe_o    = ~{mem[IX_IODIR+1], mem[IX_IODIR]};
  assign pin_o       = {mem[IX_OLAT+1], mem[IX_OLAT]};
  assign pullup_en_o = {mem[IX_GPPU+1], mem[IX_GPPU]};
endmodule

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander
  import spi_gpio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_OPCODE  = 7'h20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        cs_ni,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        miso_oe_o,
  input  logic [15:0] pin_i,
  output logic [15:0] pin_o,
  output logic [15:0] pin_oe_o,
  output logic [15:0] pullup_en_o
);
  logic [BYTE_W-1:0] rx_byte, tx_byte, rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr, ptr;
  logic rx_valid, sel, miso_bit, tx_load, wr_en, rd_phase;
  phase_e phase;

  spi_gpio_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .cs_ni     (cs_ni),
    .mosi_i    (mosi_i),
    .tx_byte_i (tx_byte),
    .tx_load_i (tx_load),
    .rx_byte_o (rx_byte),
    .rx_valid_o(rx_valid),
    .sel_o     (sel),
    .miso_bit_o(miso_bit)
  );

  spi_gpio_ctrl #(.DEV_OPCODE(DEV_OPCODE)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_byte_i (rx_byte),
    .rx_valid_i(rx_valid),
    .sel_i     (sel),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .tx_byte_o (tx_byte),
    .tx_load_o (tx_load),
    .rd_phase_o(rd_phase),
    .ptr_o     (ptr),
    .phase_o   (phase)
  );

  spi_gpio_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .pullup_en_o(pullup_en_o)
  );

  // raw chip select releases the line without synchronizer delay
  assign miso_oe_o = rd_phase & ~cs_ni;
  assign miso_o    = miso_oe_o & miso_bit;
endmodule

// File: rtl/spi_gpio_expander_chk.sv
module spi_gpio_expander_chk
  import spi_gpio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              miso_oe_o,
  input logic [15:0]       pin_o,
  input logic [15:0]       pin_oe_o,
  input logic [15:0]       pullup_en_o,
  input logic              wr_en,
  input logic              rd_phase,
  input logic              rx_valid,
  input logic [ADDR_W-1:0] ptr,
  input phase_e            phase
);
  a_r12_release_on_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !miso_oe_o);

  a_r9_latch_moves_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_o) |-> $past(wr_en));

  a_r6_dir_moves_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_oe_o) |-> $past(wr_en));

  a_r7_pullup_moves_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pullup_en_o) |-> $past(wr_en));

  a_r4_pointer_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && phase == PH_DATA && ptr == ADDR_LAST) |=> (ptr == '0));

  a_r2_no_write_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !rd_phase);
endmodule

bind spi_gpio_expander spi_gpio_expander_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .miso_oe_o  (miso_oe_o),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o),
  .pullup_en_o(pullup_en_o),
  .wr_en      (wr_en),
  .rd_phase   (rd_phase),
  .rx_valid   (rx_valid),
  .ptr        (ptr),
  .phase      (phase)
);

// File: tb/spi_gpio_expander_bench.sv
`timescale 1ns/1ps
module spi_gpio_expander_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic [15:0] pin_i = '0;
  logic miso_o, miso_oe_o;
  logic [15:0] pin_o, pin_oe_o, pullup_en_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] tx [0:19];
  logic [7:0] rx [0:19];
  logic       oe_b [0:19];

  always #2 clk = ~clk;

  spi_gpio_expander u_spi_gpio_expander (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .pullup_en_o(pullup_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] b, input int tail, output logic [7:0] r, output logic oe);
    r = '0;
    oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0;
      mosi = b[i];
      wait_n(HALF);
      r[i] = miso_o;
      oe = oe & miso_oe_o;
      sclk = 1'b1;
      wait_n((i == 0) ? tail : HALF);
    end
  endtask

  task automatic xfer(input int n, input int tail);
    cs_n = 1'b0;
    wait_n(HALF);
    for (int k = 0; k < n; k++) spi_byte(tx[k], (k == n - 1) ? tail : HALF, rx[k], oe_b[k]);
    cs_n = 1'b1;
    wait_n(12);
  endtask

  task automatic wr2(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1);
    tx[0] = 8'h40; tx[1] = a; tx[2] = d0; tx[3] = d1;
    xfer(4, HALF);
  endtask

  task automatic rd2(input logic [7:0] a, output logic [15:0] v);
    tx[0] = 8'h41; tx[1] = a; tx[2] = 8'h00; tx[3] = 8'h00;
    xfer(4, HALF);
    v = {rx[3], rx[2]};
  endtask

  function automatic logic [7:0] sval(input int i);
    return 8'(8'h10 + i * 7);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, ipol, pins;
    logic [7:0] junk;
    logic oe_j;
    logic oe_any;
    wait_n(5);
    rst_ni = 1'b1;
    wait_n(5);

    // reset state
    chk("R5 pin_oe_o", 32'(pin_oe_o), 32'h0);
    chk("R5 pin_o", 32'(pin_o), 32'h0);
    chk("R5 pullup_en_o", 32'(pullup_en_o), 32'h0);
    chk("R12 idle miso_oe_o", 32'(miso_oe_o), 32'h0);
    rd2(8'h00, v);
    chk("R5 direction readback", 32'(v), 32'hFFFF);
    chk("R12 oe in address byte", 32'(oe_b[1]), 32'h0);
    chk("R12 oe in data bytes", 32'(oe_b[2] & oe_b[3]), 32'h1);
    chk("R12 released after read", 32'(miso_oe_o), 32'h0);

    // direction sweep, one output pin at a time
    for (int i = 0; i < 16; i++) begin
      v = ~(16'h1 << i);
      wr2(8'h00, v[7:0], v[15:8]);
      chk("R6 one output pin", 32'(pin_oe_o), 32'(16'h1 << i));
      chk("R2 no MISO in write", 32'(oe_b[2] | oe_b[3]), 32'h0);
    end

    // latch through the pin-level address, A byte then B byte
    wr2(8'h12, 8'h5A, 8'hC3);
    chk("R3 R8 latch via level address", 32'(pin_o), 32'hC35A);
    rd2(8'h14, v);
    chk("R9 latch readback", 32'(v), 32'hC35A);
    wr2(8'h14, 8'h96, 8'h69);
    chk("R9 latch write", 32'(pin_o), 32'h6996);

    // level reads with inversion
    for (int k = 0; k < 8; k++) begin
      ipol = 16'(k * 16'h2B1D);
      pins = 16'hA5C3 ^ 16'(k * 16'h1111);
      wr2(8'h02, ipol[7:0], ipol[15:8]);
      pin_i = pins;
      wait_n(8);
      rd2(8'h12, v);
      chk("R8 level xor inversion", 32'(v), 32'(pins ^ ipol));
    end

    wr2(8'h0C, 8'h3C, 8'hC3);
    chk("R7 pull-up", 32'(pullup_en_o), 32'hC33C);

    // storage burst 0x04..0x11
    tx[0] = 8'h40; tx[1] = 8'h04;
    for (int i = 0; i < 14; i++) tx[2 + i] = sval(i);
    xfer(16, HALF);
    chk("R7 pull-up from burst", 32'(pullup_en_o), 32'({sval(9), sval(8)}));
    tx[0] = 8'h41; tx[1] = 8'h04;
    for (int i = 0; i < 14; i++) tx[2 + i] = 8'h00;
    xfer(16, HALF);
    for (int i = 0; i < 14; i++) begin
      if (i == 6 || i == 7) chk("R11 hole reads zero", 32'(rx[2 + i]), 32'h0);
      else chk("R10 storage readback", 32'(rx[2 + i]), 32'(sval(i)));
    end
    rd2(8'h16, v);
    chk("R11 beyond map reads zero", 32'(v), 32'h0);
    rd2(8'h30, v);
    chk("R11 far address reads zero", 32'(v), 32'h0);

    // wrap after 0x15
    wr2(8'h00, 8'hFF, 8'hFF);
    tx[0] = 8'h40; tx[1] = 8'h14; tx[2] = 8'h11; tx[3] = 8'h22; tx[4] = 8'h33;
    xfer(5, HALF);
    chk("R4 latch before wrap", 32'(pin_o), 32'h2211);
    chk("R4 direction after wrap", 32'(pin_oe_o), 32'h00CC);
    tx[0] = 8'h41; tx[1] = 8'h15; tx[2] = 8'h00; tx[3] = 8'h00; tx[4] = 8'h00;
    xfer(5, HALF);
    chk("R4 read wrap", 32'({rx[2], rx[3], rx[4]}), 32'h2233FF);

    // foreign opcodes
    tx[0] = 8'h42; tx[1] = 8'h14; tx[2] = 8'h00; tx[3] = 8'h00;
    xfer(4, HALF);
    chk("R2 bad opcode write ignored", 32'(pin_o), 32'h2211);
    tx[0] = 8'h43; tx[1] = 8'h14; tx[2] = 8'h00; tx[3] = 8'h00;
    xfer(4, HALF);
    chk("R2 bad opcode keeps MISO off", 32'(oe_b[2] | oe_b[3]), 32'h0);
    tx[0] = 8'hC0; tx[1] = 8'h14; tx[2] = 8'h00;
    xfer(3, HALF);
    chk("R2 high bit opcode ignored", 32'(pin_o), 32'h2211);

    // bit order
    wr2(8'h0C, 8'h01, 8'h80);
    chk("R1 msb first", 32'(pullup_en_o), 32'h8001);

    // partial byte dropped on deselect
    cs_n = 1'b0;
    wait_n(HALF);
    spi_byte(8'h40, HALF, junk, oe_j);
    spi_byte(8'h0C, HALF, junk, oe_j);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; mosi = 1'b1; wait_n(HALF);
      sclk = 1'b1; wait_n(HALF);
    end
    cs_n = 1'b1;
    wait_n(12);
    chk("R1 partial byte dropped", 32'(pullup_en_o), 32'h8001);

    // last byte completion meets deselect
    tx[0] = 8'h40; tx[1] = 8'h0C; tx[2] = 8'hA5;
    xfer(3, 1);
    chk("R13 late deselect write lands", 32'(pullup_en_o), 32'h80A5);

    // release timing during a read
    cs_n = 1'b0;
    wait_n(HALF);
    spi_byte(8'h41, HALF, junk, oe_j);
    spi_byte(8'h14, HALF, junk, oe_j);
    sclk = 1'b0;
    wait_n(HALF);
    oe_any = miso_oe_o;
    chk("R12 first data bit after address", 32'({oe_any, miso_o}), 32'({1'b1, 1'b0}));
    cs_n = 1'b1;
    #1;
    chk("R12 immediate release", 32'(miso_oe_o), 32'h0);
    sclk = 1'b1;
    wait_n(12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule